// File: doc/BRIEF.md
# Chassis Thermal Derating Controller

This block watches every temperature reading in a modular instrument chassis: inlet air, outlet air, the backplane hotspot and one hotspot per slot. It also watches the fan tachometer values and fan fault flags. From these it keeps the chassis in one of four named states: `ST_NORMAL`, `ST_WARN`, `ST_DERATED` and `ST_CRIT`. The hottest reading is compared against three programmable entry thresholds. Each level also has its own hysteresis value. A failed or out-of-range fan pushes the chassis to at least the derated level.

A move to a hotter state happens on the next clock edge, and it may skip levels. Cooling works differently. The chassis leaves a level only after the conditions for that level have been clear for a full hold window, and it drops one level per window. Each state drives a set of actions: a slot power-cap request, a limit on concurrent high-throughput streams, and a hot-plug inhibit. A reason code names the sensor or fan behind the current state. Every state change produces a one-cycle event pulse that carries a cycle timestamp, for the chassis log.

Named transitions: NORMAL→WARN/DERATED/CRIT, WARN→DERATED/CRIT and DERATED→CRIT are escalations, taken on the next edge. CRIT→DERATED, DERATED→WARN and WARN→NORMAL are hold-window steps down.

Top module: `thd_ctrl`

## Requirements
- R1: After reset the state is `ST_NORMAL` (code 0), reason is 0x00, power_cap_req and hotplug_inhibit are 0, stream_limit equals MAX_STREAMS, and evt_valid is 0.
- R2: State codes are NORMAL=0, WARN=1, DERATED=2, CRIT=3. The target level is the highest level whose entry threshold is less than or equal to the hottest reading. When the target is above the current state, the state becomes the target on the next clock edge, and levels may be skipped.
- R3: The hottest reading is the maximum of all temperature inputs, with index 0=inlet, 1=outlet, 2=backplane and 3+k=slot k. The lowest index wins a tie. When a state change is caused by temperature, reason = {2'b01, 6-bit index}.
- R4: A step down lowers the state by exactly one level. Going down two levels needs two full hold windows.
- R5: Hysteresis applies to every level. The chassis can leave level L only while the hottest reading is below (entry threshold of L minus hysteresis of L). A reading inside that band keeps the level for as long as it lasts.
- R6: A step down happens on the HOLD_CYCLES-th consecutive clock edge with the exit condition true. Any edge with the exit condition false restarts the count.
- R7: A fan counts as failed when its fault flag is set or its RPM is outside [rpm_min, rpm_max]. Any failed fan forces at least `ST_DERATED`. When the fan level is above the temperature level, reason = {2'b10, index of the lowest-numbered failed fan}.
- R8: The reason code changes only on a state change. It is 0x00 whenever the new state is NORMAL.
- R9: State actions are as follows. hotplug_inhibit=1 in any state other than NORMAL. power_cap_req=1 in DERATED and CRIT. stream_limit is MAX_STREAMS in NORMAL and WARN, MAX_STREAMS/2 in DERATED, and 0 in CRIT.
- R10: On every state change, evt_valid is 1 for exactly one cycle. At that point evt_time equals the number of clock edges since reset release, minus one, counted at the edge that made the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_inlet | input | TW | Inlet air temperature code |
| t_outlet | input | TW | Outlet air temperature code |
| t_backplane | input | TW | Backplane hotspot temperature code |
| t_slot | input | NUM_SLOTS*TW | Per-slot hotspot codes, slot 0 in the low bits |
| fan_rpm | input | NUM_FANS*RPM_W | Fan tachometer readings, fan 0 in the low bits |
| fan_fault | input | NUM_FANS | Fan fault flags |
| rpm_min | input | RPM_W | Lowest acceptable fan speed |
| rpm_max | input | RPM_W | Highest acceptable fan speed |
| thr_warn | input | TW | Warning entry threshold |
| thr_derate | input | TW | Derated entry threshold |
| thr_crit | input | TW | Critical entry threshold |
| hyst_warn | input | TW | Warning hysteresis |
| hyst_derate | input | TW | Derated hysteresis |
| hyst_crit | input | TW | Critical hysteresis |
| state | output | 2 | Current derating state |
| reason | output | 8 | Cause: {kind, index}; kind 1 = temperature, 2 = fan |
| power_cap_req | output | 1 | Request to cap per-slot power |
| stream_limit | output | SL_W | Allowed concurrent high-throughput streams |
| hotplug_inhibit | output | 1 | Hot-plug not permitted |
| evt_valid | output | 1 | One-cycle pulse on a state change |
| evt_time | output | TS_W | Timestamp of that change |

## Verification
Escalation, the reason code, the actions and the event pulse all show up one clock edge after the inputs that cause them. The bench therefore drives inputs on a falling edge and reads the results at the next falling edge. A step down is due at the HOLD_CYCLES-th edge once the readings are safe. Each hold test reads the outputs after HOLD_CYCLES-1 edges and expects the old state, then advances one more edge and expects the lower state. The event timestamp is compared against an edge counter kept in the bench since reset release.

// File: rtl/thd_pkg.sv
package thd_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_WARN    = 2'd1,
        ST_DERATED = 2'd2,
        ST_CRIT    = 2'd3
    } therm_state_t;

    localparam logic [1:0] SRC_NONE = 2'd0;
    localparam logic [1:0] SRC_TEMP = 2'd1;
    localparam logic [1:0] SRC_FAN  = 2'd2;

    localparam int RSN_IDX_W = 6;

endpackage

// File: rtl/thd_temp_max.sv
module thd_temp_max #(
    parameter int N  = 7,
    parameter int TW = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*TW-1:0] vals,
    output logic [TW-1:0]   max_val,
    output logic [IW-1:0]   max_idx
);

    always_comb begin
        max_val = vals[TW-1:0];
        max_idx = '0;
        for (int i = 1; i < N; i++) begin
            if (vals[i*TW +: TW] > max_val) begin
                max_val = vals[i*TW +: TW];
                max_idx = IW'(i);
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cover
            p_max_cover_r3: assert property (@(posedge clk) disable iff (!rst_n)
                max_val >= vals[g*TW +: TW]);
        end
    endgenerate

endmodule

// File: rtl/thd_fan_check.sv
module thd_fan_check #(
    parameter int NF    = 2,
    parameter int RPM_W = 16,
    parameter int IW    = 6
) (
    input  logic [NF*RPM_W-1:0] fan_rpm,
    input  logic [NF-1:0]       fan_fault,
    input  logic [RPM_W-1:0]    rpm_min,
    input  logic [RPM_W-1:0]    rpm_max,
    output logic                alarm,
    output logic [IW-1:0]       idx
);

    logic [NF-1:0] bad;

    generate
        for (genvar g = 0; g < NF; g++) begin : g_fan
            assign bad[g] = fan_fault[g]
                          || (fan_rpm[g*RPM_W +: RPM_W] < rpm_min)
                          || (fan_rpm[g*RPM_W +: RPM_W] > rpm_max);
        end
    endgenerate

    always_comb begin
        alarm = 1'b0;
        idx   = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (bad[i]) begin
                alarm = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/thd_hold_timer.sv
module thd_hold_timer #(
    parameter int HOLD = 64,
    parameter int CW   = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic safe,
    output logic expire
);

    logic [CW-1:0] cnt;

    assign expire = safe && !clear && (cnt == CW'(HOLD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !safe || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(HOLD));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !safe |=> (cnt == '0));

endmodule

// File: rtl/thd_ctrl.sv
module thd_ctrl
    import thd_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_FANS    = 2,
    parameter int TW          = 12,
    parameter int RPM_W       = 16,
    parameter int HOLD_CYCLES = 64,
    parameter int MAX_STREAMS = 8,
    parameter int TS_W        = 32,
    parameter int SL_W        = $clog2(MAX_STREAMS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TW-1:0]             t_inlet,
    input  logic [TW-1:0]             t_outlet,
    input  logic [TW-1:0]             t_backplane,
    input  logic [NUM_SLOTS*TW-1:0]   t_slot,
    input  logic [NUM_FANS*RPM_W-1:0] fan_rpm,
    input  logic [NUM_FANS-1:0]       fan_fault,
    input  logic [RPM_W-1:0]          rpm_min,
    input  logic [RPM_W-1:0]          rpm_max,
    input  logic [TW-1:0]             thr_warn,
    input  logic [TW-1:0]             thr_derate,
    input  logic [TW-1:0]             thr_crit,
    input  logic [TW-1:0]             hyst_warn,
    input  logic [TW-1:0]             hyst_derate,
    input  logic [TW-1:0]             hyst_crit,
    output logic [1:0]                state,
    output logic [7:0]                reason,
    output logic                      power_cap_req,
    output logic [SL_W-1:0]           stream_limit,
    output logic                      hotplug_inhibit,
    output logic                      evt_valid,
    output logic [TS_W-1:0]           evt_time
);

    localparam int NT  = NUM_SLOTS + 3;
    localparam int TIW = (NT > 1) ? $clog2(NT) : 1;

    therm_state_t        state_q, state_n;
    logic [TW-1:0]       tmax;
    logic [TIW-1:0]      tidx;
    logic                fan_alarm;
    logic [RSN_IDX_W-1:0] fidx;
    logic [1:0]          temp_lvl, fan_lvl, target;
    logic [TW-1:0]       exit_thr;
    logic                safe, escalate, expire;
    logic [7:0]          reason_q, reason_n;
    logic [TS_W-1:0]     ts;

    function automatic logic [TW-1:0] sat_sub(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    thd_temp_max #(.N(NT), .TW(TW), .IW(TIW)) u_tmax (
        .clk     (clk),
        .rst_n   (rst_n),
        .vals    ({t_slot, t_backplane, t_outlet, t_inlet}),
        .max_val (tmax),
        .max_idx (tidx)
    );

    thd_fan_check #(.NF(NUM_FANS), .RPM_W(RPM_W), .IW(RSN_IDX_W)) u_fan (
        .fan_rpm   (fan_rpm),
        .fan_fault (fan_fault),
        .rpm_min   (rpm_min),
        .rpm_max   (rpm_max),
        .alarm     (fan_alarm),
        .idx       (fidx)
    );

    thd_hold_timer #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (escalate),
        .safe   (safe),
        .expire (expire)
    );

    // Level demanded by the readings
    always_comb begin
        if (tmax >= thr_crit)        temp_lvl = 2'd3;
        else if (tmax >= thr_derate) temp_lvl = 2'd2;
        else if (tmax >= thr_warn)   temp_lvl = 2'd1;
        else                         temp_lvl = 2'd0;
        fan_lvl  = fan_alarm ? 2'd2 : 2'd0;
        target   = (fan_lvl > temp_lvl) ? fan_lvl : temp_lvl;
        escalate = target > state_q;
    end

    // Exit condition for the current level
    always_comb begin
        unique case (state_q)
            ST_NORMAL:  exit_thr = '0;
            ST_WARN:    exit_thr = sat_sub(thr_warn, hyst_warn);
            ST_DERATED: exit_thr = sat_sub(thr_derate, hyst_derate);
            ST_CRIT:    exit_thr = sat_sub(thr_crit, hyst_crit);
            default:    exit_thr = '0;
        endcase
        safe = (state_q != ST_NORMAL) && (tmax < exit_thr) && (fan_lvl < state_q);
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_NORMAL:  if (escalate) state_n = therm_state_t'(target);
            ST_WARN:    if (escalate) state_n = therm_state_t'(target);
                        else if (expire) state_n = ST_NORMAL;
            ST_DERATED: if (escalate) state_n = therm_state_t'(target);
                        else if (expire) state_n = ST_WARN;
            ST_CRIT:    if (expire) state_n = ST_DERATED;
            default:    state_n = ST_NORMAL;
        endcase
    end

    // Cause attached to the new state
    always_comb begin
        if (state_n == ST_NORMAL)
            reason_n = {SRC_NONE, RSN_IDX_W'(0)};
        else if (fan_alarm && (fan_lvl > temp_lvl))
            reason_n = {SRC_FAN, fidx};
        else
            reason_n = {SRC_TEMP, RSN_IDX_W'(tidx)};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_NORMAL;
            reason_q  <= '0;
            evt_valid <= 1'b0;
            evt_time  <= '0;
            ts        <= '0;
        end else begin
            ts        <= ts + 1'b1;
            state_q   <= state_n;
            evt_valid <= (state_n != state_q);
            if (state_n != state_q) begin
                reason_q <= reason_n;
                evt_time <= ts;
            end
        end
    end

    // Actions per state
    always_comb begin
        state           = state_q;
        reason          = reason_q;
        power_cap_req   = 1'b0;
        hotplug_inhibit = 1'b1;
        stream_limit    = SL_W'(MAX_STREAMS);
        unique case (state_q)
            ST_NORMAL:  hotplug_inhibit = 1'b0;
            ST_WARN:    ;
            ST_DERATED: begin
                power_cap_req = 1'b1;
                stream_limit  = SL_W'(MAX_STREAMS / 2);
            end
            ST_CRIT: begin
                power_cap_req = 1'b1;
                stream_limit  = '0;
            end
            default: ;
        endcase
    end

    p_escalate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (target > state_q) |=> (state_q == $past(target)));

    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q < $past(state_q)) |-> (state_q == $past(state_q) - 2'd1));

    p_hyst_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_NORMAL) && (tmax >= exit_thr)) |=> (state_q >= $past(state_q)));

    p_fan_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fan_alarm |=> (state_q >= ST_DERATED));

    p_reason_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reason_q[7:6] != 2'b11) && ((state_q == ST_NORMAL) == (reason_q == 8'h00)));

    p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> evt_valid);

endmodule

// File: tb/tb_thd_ctrl.sv
`timescale 1ns/1ps
module tb_thd_ctrl;

    localparam int NS = 4, NF = 2, TW = 12, RW = 16, HOLD = 8, MS = 8, TSW = 32;
    localparam int SLW = $clog2(MS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] t_in, t_out, t_bp;
    logic [NS*TW-1:0] t_sl;
    logic [NF*RW-1:0] rpm;
    logic [NF-1:0] ffault;
    logic [1:0] state;
    logic [7:0] reason;
    logic pcap, hpi, evt_v;
    logic [SLW-1:0] slim;
    logic [TSW-1:0] evt_t;
    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    thd_ctrl #(.NUM_SLOTS(NS), .NUM_FANS(NF), .TW(TW), .RPM_W(RW),
               .HOLD_CYCLES(HOLD), .MAX_STREAMS(MS), .TS_W(TSW)) dut (
        .clk(clk), .rst_n(rst_n),
        .t_inlet(t_in), .t_outlet(t_out), .t_backplane(t_bp), .t_slot(t_sl),
        .fan_rpm(rpm), .fan_fault(ffault),
        .rpm_min(16'd1000), .rpm_max(16'd5000),
        .thr_warn(12'd600), .thr_derate(12'd800), .thr_crit(12'd1000),
        .hyst_warn(12'd50), .hyst_derate(12'd50), .hyst_crit(12'd50),
        .state(state), .reason(reason), .power_cap_req(pcap),
        .stream_limit(slim), .hotplug_inhibit(hpi),
        .evt_valid(evt_v), .evt_time(evt_t)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic all_temps(input int v);
        t_in = TW'(v); t_out = TW'(v); t_bp = TW'(v);
        for (int i = 0; i < NS; i++) t_sl[i*TW +: TW] = TW'(v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        all_temps(100);
        rpm = {16'd3000, 16'd3000};
        ffault = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic check_actions(input int st, input string tag);
        chk(state, st, tag);
        chk(hpi, (st != 0) ? 1 : 0, tag);
        chk(pcap, (st >= 2) ? 1 : 0, tag);
        chk(slim, (st == 3) ? 0 : (st == 2) ? MS / 2 : MS, tag);
    endtask

    task automatic t_reset_state();
        do_reset();
        check_actions(0, "R1 reset");
        chk(reason, 0, "R1 reason");
        chk(evt_v, 0, "R1 evt");
    endtask

    task automatic t_escalate();
        do_reset();
        step(3);
        t_bp = 12'd650;
        step(1);
        check_actions(1, "R2 warn entry R9");
        chk(evt_v, 1, "R10 pulse");
        chk(evt_t, cyc - 1, "R10 time");
        step(1);
        chk(evt_v, 0, "R10 single cycle");
        t_bp = 12'd1200;
        step(1);
        check_actions(3, "R2 warn to crit R9");
        do_reset();
        t_in = 12'd1000;
        step(1);
        chk(state, 3, "R2 normal to crit skip");
        chk(reason, 8'h40, "R3 inlet index");
    endtask

    task automatic t_reason();
        do_reset();
        t_out = 12'd700;
        t_sl[2*TW +: TW] = 12'd700;
        step(1);
        chk(reason, 8'h41, "R3 tie lowest index");
        t_sl[3*TW +: TW] = 12'd900;
        step(1);
        chk(state, 2, "R2 warn to derated");
        chk(reason, 8'h46, "R3 slot3 index");
        t_sl[3*TW +: TW] = 12'd950;
        step(2);
        chk(reason, 8'h46, "R8 reason held without change");
    endtask

    task automatic t_hyst_hold();
        do_reset();
        t_sl[0 +: TW] = 12'd1050;
        step(1);
        chk(state, 3, "R2 crit");
        t_sl[0 +: TW] = 12'd960;
        step(3 * HOLD);
        chk(state, 3, "R5 inside band holds");
        t_sl[0 +: TW] = 12'd900;
        step(HOLD - 1);
        chk(state, 3, "R6 before window");
        step(1);
        check_actions(2, "R4 crit to derated R9");
        step(2 * HOLD);
        chk(state, 2, "R5 derated band holds");
        all_temps(100);
        step(HOLD);
        chk(state, 1, "R4 one level only");
        step(HOLD - 1);
        chk(state, 1, "R6 second window");
        step(1);
        chk(state, 0, "R4 reach normal");
        chk(reason, 0, "R8 normal reason");
    endtask

    task automatic t_hold_restart();
        do_reset();
        t_out = 12'd650;
        step(1);
        chk(state, 1, "R2 warn");
        t_out = 12'd100;
        step(HOLD - 2);
        t_out = 12'd580;
        step(1);
        chk(state, 1, "R5 band blocks");
        t_out = 12'd100;
        step(HOLD - 1);
        chk(state, 1, "R6 count restarted");
        step(1);
        chk(state, 0, "R6 step after full window");
    endtask

    task automatic t_fan();
        do_reset();
        rpm[RW +: RW] = 16'd500;
        step(1);
        check_actions(2, "R7 low rpm R9");
        chk(reason, 8'h81, "R7 fan1 reason");
        rpm[RW +: RW] = 16'd3000;
        ffault[0] = 1'b1;
        step(HOLD + 2);
        chk(state, 2, "R7 fault holds derated");
        chk(reason, 8'h81, "R8 reason unchanged");
        ffault[0] = 1'b0;
        step(HOLD);
        chk(state, 1, "R4 fan clear step");
        chk(reason, 8'h40, "R8 reason on step");
        do_reset();
        rpm[0 +: RW] = 16'd6000;
        step(1);
        chk(state, 2, "R7 high rpm");
        chk(reason, 8'h80, "R7 fan0 reason");
    endtask

    initial begin
        t_reset_state();
        t_escalate();
        t_reason();
        t_hyst_hold();
        t_hold_restart();
        t_fan();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule